// File: doc/BRIEF.md
# Framed Serial-to-Parallel Receiver

This block takes a bit stream that arrives one bit per enabled clock cycle on a single line and turns each framed byte into a parallel word. Every frame opens with a start bit at logic 1. A payload of eight bits follows, most significant first, and the frame closes with one parity bit. The receiver checks the parity bit against the one it computes from the payload. On a match it updates its parallel output and pulses a ready flag for one clock.

On a mismatch it pulls an active-low error flag and runs a short internal recovery. During that recovery the line is not watched at all. When the recovery ends, the receiver is back in its hunting state and waits for the next start bit. The parallel output keeps the last good byte until a newer good frame replaces it, so a downstream consumer can read it at any time.

Top module: `serial_frame_rx`

## Requirements
- R1: While `rstN` is low and right after it is released, `ready` is 0, `parErrN` is 1 and `dataOut` is all zeros.
- R2: The idle line level is 0. A frame starts only when `serIn` is 1 on a cycle with `bitEn` high, so an idle line at 0 never produces `ready` or an error.
- R3: The eight payload bits after the start bit are taken most significant bit first. After a good frame, `dataOut[7]` holds the first payload bit and `dataOut[0]` holds the last one.
- R4: `ready` goes to 1 for exactly one clock, in the cycle right after the clock edge that samples the parity bit. It never goes high in any other cycle.
- R5: With the default `PARITY_ODD = 0`, parity is even: a frame is good when its parity bit equals the XOR of the eight payload bits.
- R6: When the parity bit mismatches, `parErrN` goes to 0 in the cycle after the parity sample and stays at 0 for exactly `RECOVER_CYC` clocks. `ready` stays 0 for that frame.
- R7: Every input seen during the recovery interval is ignored, including enabled 1s. When the interval ends, the receiver is hunting for a start bit again.
- R8: On cycles where `bitEn` is 0, `serIn` has no effect, and frame progress waits for the next enabled cycle.
- R9: `dataOut` changes only together with a `ready` pulse. After a parity error it keeps the last good byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | High on cycles that carry one line bit |
| serIn | input | 1 | Serial line input |
| dataOut | output | DATA_W | Last correctly received payload |
| ready | output | 1 | One-cycle pulse when a good frame completes |
| parErrN | output | 1 | Active-low parity error, held low during recovery |

## Verification
The bench builds the receiver with `DATA_W = 8`, even parity and `RECOVER_CYC = 3`. Using a recovery length different from the default shows that the low time of the error flag follows the parameter and is not fixed. Three enabled 1s are driven into the recovery window, one per recovery cycle, so a receiver that treats any of them as a start bit loses frame alignment on the byte that follows. Disabled cycles carrying 1s are placed between frame bits, and frames are sent back to back, which exercises the hold-off and the restart from the hunting state.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  typedef enum logic [1:0] {
    RX_HUNT    = 2'd0,
    RX_PAYLOAD = 2'd1,
    RX_PARITY  = 2'd2,
    RX_RECOVER = 2'd3
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;    // take one payload bit
    logic capture;  // publish the shift register
    logic clear;    // recovery wipe of the shift register
  } rxStrobes_t;

endpackage

// File: rtl/frame_rx_datapath.sv
module frame_rx_datapath
  import frame_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  rxStrobes_t        strobes,
  output logic              parityOk,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] shReg;
  logic              expBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobes.clear) begin
      shReg <= '0;
    end else if (strobes.shift) begin
      shReg <= {shReg[DATA_W-2:0], serIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (strobes.capture) begin
      dataOut <= shReg;
    end
  end

  generate
    if (PARITY_ODD) begin : g_oddPar
      assign expBit = ~(^shReg);
    end else begin : g_evenPar
      assign expBit = ^shReg;
    end
  endgenerate

  assign parityOk = (serIn == expBit);

endmodule

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
  import frame_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RECOVER_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       serIn,
  input  logic       parityOk,
  output rxStrobes_t strobes,
  output logic       ready,
  output logic       parErrN
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int REC_W = $clog2(RECOVER_CYC + 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOVER_CYC - 1);

  rxState_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic [REC_W-1:0] recCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_HUNT;
      bitCnt  <= '0;
      recCnt  <= '0;
      ready   <= 1'b0;
      parErrN <= 1'b1;
    end else begin
      ready <= 1'b0;
      unique case (state)
        RX_HUNT: begin
          if (bitEn && serIn) begin
            state  <= RX_PAYLOAD;
            bitCnt <= '0;
          end
        end
        RX_PAYLOAD: begin
          if (bitEn) begin
            if (bitCnt == BIT_LAST) begin
              state <= RX_PARITY;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        RX_PARITY: begin
          if (bitEn) begin
            if (parityOk) begin
              ready <= 1'b1;
              state <= RX_HUNT;
            end else begin
              parErrN <= 1'b0;
              recCnt  <= '0;
              state   <= RX_RECOVER;
            end
          end
        end
        RX_RECOVER: begin
          if (recCnt == REC_LAST) begin
            parErrN <= 1'b1;
            state   <= RX_HUNT;
          end else begin
            recCnt <= recCnt + 1'b1;
          end
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

  always_comb begin
    strobes.shift   = (state == RX_PAYLOAD) && bitEn;
    strobes.capture = (state == RX_PARITY) && bitEn && parityOk;
    strobes.clear   = (state == RX_RECOVER);
  end

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import frame_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RECOVER_CYC = 2,
  parameter bit PARITY_ODD  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              serIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              ready,
  output logic              parErrN
);

  rxStrobes_t strobes;
  logic       parityOk;

  frame_rx_ctrl #(
    .DATA_W      (DATA_W),
    .RECOVER_CYC (RECOVER_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .serIn    (serIn),
    .parityOk (parityOk),
    .strobes  (strobes),
    .ready    (ready),
    .parErrN  (parErrN)
  );

  frame_rx_datapath #(
    .DATA_W     (DATA_W),
    .PARITY_ODD (PARITY_ODD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .strobes  (strobes),
    .parityOk (parityOk),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/frame_rx_checker.sv
module frame_rx_checker #(
  parameter int DATA_W      = 8,
  parameter int RECOVER_CYC = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitEn,
  input logic [DATA_W-1:0] dataOut,
  input logic              ready,
  input logic              parErrN
);

  localparam int LOW_W = $clog2(RECOVER_CYC + 2) + 1;

  logic [LOW_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (parErrN) begin
      lowCnt <= '0;
    end else begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (!ready && parErrN && (dataOut == '0));
    end
  end

  // R4
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

  // R4
  ready_after_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> $past(bitEn));

  // R6
  err_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LOW_W'(RECOVER_CYC));

  // R6
  err_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !parErrN |-> !ready);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> ready);

endmodule

bind serial_frame_rx frame_rx_checker #(
  .DATA_W      (DATA_W),
  .RECOVER_CYC (RECOVER_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bitEn   (bitEn),
  .dataOut (dataOut),
  .ready   (ready),
  .parErrN (parErrN)
);

// File: tb/tb_serial_frame_rx.sv
module tb_serial_frame_rx;

  localparam int W  = 8;
  localparam int RC = 3;

  typedef struct {
    bit           isErr;
    logic [W-1:0] data;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bitEn = 1'b0;
  logic         serIn = 1'b0;
  logic [W-1:0] dataOut;
  logic         ready;
  logic         parErrN;

  int checks = 0;
  int errors = 0;
  int eventCnt = 0;
  int lowLen = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  bit prevErrN = 1'b1;
  bit prevReady = 1'b0;
  logic [W-1:0] lastGood = '0;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  serial_frame_rx #(
    .DATA_W      (W),
    .RECOVER_CYC (RC),
    .PARITY_ODD  (1'b0)
  ) dut (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .serIn   (serIn),
    .dataOut (dataOut),
    .ready   (ready),
    .parErrN (parErrN)
  );

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic sendBit(bit b, int gap);
    repeat (gap) begin
      @(negedge clk);
      bitEn = 1'b0;
      serIn = 1'b1;
    end
    @(negedge clk);
    bitEn = 1'b1;
    serIn = b;
  endtask

  task automatic sendFrame(logic [W-1:0] d, bit corrupt, int gap, string tag);
    expItem_t it;
    it.isErr = corrupt;
    it.data  = d;
    it.tag   = tag;
    expQ.push_back(it);
    sendBit(1'b1, gap);
    for (int i = W - 1; i >= 0; i--) sendBit(d[i], gap);
    sendBit((^d) ^ corrupt, gap);
  endtask

  task automatic idleLine(int n);
    repeat (n) begin
      @(negedge clk);
      bitEn = 1'b1;
      serIn = 1'b0;
    end
  endtask

  // enabled 1s on every recovery cycle, R7
  task automatic recoveryNoise();
    repeat (RC) begin
      @(negedge clk);
      bitEn = 1'b1;
      serIn = 1'b1;
    end
    idleLine(1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && monOn) begin
      if (ready) begin
        eventCnt++;
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected ready", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(!it.isErr, it.tag, "ready on corrupt frame", 1, 0);
          check(dataOut == it.data, it.tag, "dataOut", int'(dataOut), int'(it.data));
          lastGood = it.data;
        end
        check(!prevReady, "R4", "ready longer than one cycle", 1, 0);
      end
      if (!parErrN && prevErrN) begin
        eventCnt++;
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected parity error", 0, 1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.isErr, it.tag, "parity error on good frame", 0, 1);
          check(dataOut == lastGood, "R9", "dataOut after error", int'(dataOut), int'(lastGood));
        end
      end
      if (!parErrN) lowLen++;
      if (parErrN && !prevErrN) begin
        check(lowLen == RC, "R6", "error low length", lowLen, RC);
        lowLen = 0;
      end
      prevErrN = parErrN;
      prevReady = ready;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int evBefore;
    bitEn = 1'b1;
    serIn = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs during reset, inputs active
    check(!ready && parErrN && dataOut == '0, "R1", "state in reset",
          int'({ready, parErrN, dataOut}), int'({1'b0, 1'b1, 8'h00}));
    rstN = 1'b1;
    bitEn = 1'b0;
    serIn = 1'b0;
    @(negedge clk);
    check(!ready && parErrN && dataOut == '0, "R1", "state after reset",
          int'({ready, parErrN, dataOut}), int'({1'b0, 1'b1, 8'h00}));
    monOn = 1'b1;

    // R2: idle zeros start nothing
    idleLine(20);
    check(eventCnt == 0, "R2", "events on idle line", eventCnt, 0);

    sendFrame(8'hA5, 1'b0, 0, "R3");
    idleLine(2);
    sendFrame(8'h3C, 1'b0, 1, "R8");
    sendFrame(8'h00, 1'b0, 0, "R3");
    sendFrame(8'hFF, 1'b0, 0, "R3");
    sendFrame(8'h80, 1'b0, 2, "R5");
    idleLine(3);
    sendFrame(8'h01, 1'b0, 0, "R5");
    idleLine(2);

    sendFrame(8'h5A, 1'b1, 0, "R6");
    recoveryNoise();
    evBefore = eventCnt;
    idleLine(10);
    check(eventCnt == evBefore, "R7", "events after recovery noise", eventCnt, evBefore);
    check(dataOut == 8'h01, "R9", "dataOut held", int'(dataOut), 8'h01);
    sendFrame(8'hC3, 1'b0, 0, "R7");
    idleLine(2);

    sendFrame(8'h00, 1'b1, 1, "R6");
    recoveryNoise();
    sendFrame(8'h7E, 1'b0, 0, "R7");
    idleLine(6);

    check(expQ.size() == 0, "R3", "frames left unanswered", expQ.size(), 0);
    check(dataOut == 8'h7E, "R9", "final dataOut", int'(dataOut), 8'h7E);
    check(parErrN == 1'b1, "R6", "error flag released", int'(parErrN), 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule